// File: doc/BRIEF.md
# Multibank Row-Register Cache Controller

This block sits in front of a banked DRAM array. The array is split into independent banks, and each bank keeps a copy of one complete row in its own row register. Every read is answered from a row register and never straight from the array. A read address is cut into three fields: a column offset, a bank select and a row number. A per-bank tag holding the last row loaded into that bank decides whether the read hits or misses.

On a hit the word comes back on the next cycle, and the controller stays ready for another request. On a miss the controller drops its ready signal for a fixed, configurable number of cycles. It then copies the whole row from the array into the bank's row register, records the new row in the bank's tag and returns the word. The write port is separate and is accepted in every cycle, including during a fill. Each write updates the array. It also updates a bank's row register when the write's bank and row match that bank's tag, so cached data never goes stale.

The default sizes are small for simulation: 4 banks, 8 rows and 16 columns of 8-bit words. All sizes are parameters.

Top module: `rowcache_ctrl`

## Requirements
- R1: The address is laid out as {row, bank, column}, with the column in bits [COL_W-1:0], the bank select in the BANK_W bits directly above it, and the row in the top ROW_W bits. A read returns the last word written to exactly that address.
- R2: After reset, rd_ready is 1 and rd_valid is 0, and every bank tag is invalid. The first read to each bank is therefore handled as a miss.
- R3: A read accepted while rd_ready is 1 hits when the bank's tag is valid and equals the requested row. On a hit, rd_valid is 1 with the data in the next cycle, and rd_ready never drops.
- R4: A read that misses holds rd_ready at 0 for exactly MISS_LAT cycles after it is accepted. rd_valid then rises with the data, with rd_ready back at 1 in that same cycle.
- R5: Once a miss completes, the bank's tag holds the new row, so later reads to that bank and row hit.
- R6: Banks are independent: a miss in one bank leaves the rows cached in the other banks in place.
- R7: A write is accepted in every cycle, including while a fill is in progress, and always updates the array.
- R8: A write whose bank and row match that bank's tag also updates the bank's row register, so a later hit returns the new value.
- R9: When a write targets the word a read returns and the write lands in the cycle the read is accepted (hit or miss) or in any cycle of a miss fill, the read returns the written value.
- R10: A read request made while rd_ready is 0 is ignored: the block produces exactly one rd_valid pulse for each accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Read request, taken when rd_ready is 1 |
| rd_addr | input | ROW_W+BANK_W+COL_W | Read address {row, bank, column} |
| rd_ready | output | 1 | High when a read request can be accepted |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | DATA_W | Read data |
| wr_en | input | 1 | Write strobe, taken every cycle |
| wr_addr | input | ROW_W+BANK_W+COL_W | Write address {row, bank, column} |
| wr_data | input | DATA_W | Write data |

## Verification
A write and a read can land on the same word in the same cycle, on either a cached hit or a pending fill. The bench provokes this by driving the write beside the read request. It also drives the write in the first fill cycle and in the last fill cycle, where the array update and the row load coincide. It expects the read to return the written value, and it also checks the latency and how long the ready signal stays low. Separate sweeps read every address after full-array writes, with tag rows placed to give both hits and misses in each bank.

// File: rtl/rowcache_pkg.sv
// Package: shared types for the row-register cache controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rowcache_pkg;

    // Controller state: idle accepts reads, fill waits out a row reload.
    typedef enum logic {
        RC_IDLE = 1'b0,
        RC_FILL = 1'b1
    } rc_state_t;

endpackage

// File: rtl/rowcache_array.sv
// Module: rowcache_array
// Banked backing storage. One write port for a single word, and one
// combinational port that reads a whole row of a chosen bank.
// Assumes: the caller merges a same-cycle write into the row it reads.
module rowcache_array #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 3,
    parameter int COL_W  = 4
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [BANK_W-1:0]         wr_bank,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [COL_W-1:0]          wr_col,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [BANK_W-1:0]         rd_bank,
    input  logic [ROW_W-1:0]          rd_row,
    output logic [DATA_W*(1<<COL_W)-1:0] row_data
);
    localparam int COLS  = 1 << COL_W;
    localparam int IDX_W = BANK_W + ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [0:DEPTH-1];

    // Store one word per write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_row, wr_col}] <= wr_data;
        end
    end

    // Present every column of the selected row at once.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign row_data[c*DATA_W +: DATA_W] = mem[{rd_bank, rd_row, COL_W'(c)}];
    end

endmodule

// File: rtl/rowcache_tags.sv
// Module: rowcache_tags
// Per-bank last-row tags with valid bits, and two comparators: one for the
// read path and one for the write path.
// Assumes: set_en is pulsed once per completed row reload.
module rowcache_tags #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_hit,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    output logic              wr_hit
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] valid_q;
    logic [ROW_W-1:0] tag_q [NBANK];

    // Valid bits: cleared by reset, set when a bank finishes a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_bank] <= 1'b1;
        end
    end

    // Tag rows: record the row just loaded into the bank.
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_bank] <= set_row;
        end
    end

    // Comparators for the read and write lookups.
    always_comb begin
        rd_hit = valid_q[rd_bank] && (tag_q[rd_bank] == rd_row);
        wr_hit = valid_q[wr_bank] && (tag_q[wr_bank] == wr_row);
    end

    // After a reload the bank must report the loaded row as cached.
    assert_tag_loaded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (valid_q[$past(set_bank)] && (tag_q[$past(set_bank)] == $past(set_row))));

endmodule

// File: rtl/rowcache_rowbuf.sv
// Module: rowcache_rowbuf
// Row registers, one full row per bank. A reload replaces a whole row.
// A write that hits the bank's tag updates a single word.
// Assumes: load data already carries any write made in the load cycle.
module rowcache_rowbuf #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int COL_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [BANK_W-1:0]            load_bank,
    input  logic [DATA_W*(1<<COL_W)-1:0] load_data,
    input  logic                         wr_en,
    input  logic                         wr_hit,
    input  logic [BANK_W-1:0]            wr_bank,
    input  logic [COL_W-1:0]             wr_col,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [BANK_W-1:0]            rd_bank,
    input  logic [COL_W-1:0]             rd_col,
    output logic [DATA_W-1:0]            rd_word
);
    localparam int NBANK = 1 << BANK_W;
    localparam int COLS  = 1 << COL_W;

    logic [DATA_W-1:0] rr [NBANK][COLS];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Bank storage: a reload takes priority over a word update.
        always_ff @(posedge clk) begin
            if (load_en && (load_bank == BANK_W'(b))) begin
                for (int c = 0; c < COLS; c++) begin
                    rr[b][c] <= load_data[c*DATA_W +: DATA_W];
                end
            end else if (wr_en && wr_hit && (wr_bank == BANK_W'(b))) begin
                rr[b][wr_col] <= wr_data;
            end
        end
    end

    // Read port of the selected bank's row register.
    assign rd_word = rr[rd_bank][rd_col];

    // A hitting write must be visible in the row register one cycle later.
    assert_write_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && !(load_en && (load_bank == wr_bank)))
        |=> (rr[$past(wr_bank)][$past(wr_col)] == $past(wr_data)));

endmodule

// File: rtl/rowcache_ctrl.sv
// Module: rowcache_ctrl (top)
// Read front end for a banked array. It serves reads from per-bank row
// registers, reloads a row on a miss after MISS_LAT stall cycles, and
// writes through to both the array and any matching row register.
// Assumes: address = {row, bank, column}; MISS_LAT >= 1.
module rowcache_ctrl
    import rowcache_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BANK_W   = 2,
    parameter int ROW_W    = 3,
    parameter int COL_W    = 4,
    parameter int MISS_LAT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_req,
    input  logic [ROW_W+BANK_W+COL_W-1:0]    rd_addr,
    output logic                             rd_ready,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data,
    input  logic                             wr_en,
    input  logic [ROW_W+BANK_W+COL_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]                wr_data
);
    localparam int COLS  = 1 << COL_W;
    localparam int ROWBITS = DATA_W * COLS;
    localparam int CNT_W = (MISS_LAT > 1) ? $clog2(MISS_LAT) : 1;

    // Address fields.
    logic [COL_W-1:0]  rd_col,  wr_col;
    logic [BANK_W-1:0] rd_bank, wr_bank;
    logic [ROW_W-1:0]  rd_row,  wr_row;

    assign rd_col  = rd_addr[COL_W-1:0];
    assign rd_bank = rd_addr[COL_W +: BANK_W];
    assign rd_row  = rd_addr[COL_W+BANK_W +: ROW_W];
    assign wr_col  = wr_addr[COL_W-1:0];
    assign wr_bank = wr_addr[COL_W +: BANK_W];
    assign wr_row  = wr_addr[COL_W+BANK_W +: ROW_W];

    // Controller state and the pending miss.
    rc_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BANK_W-1:0] pend_bank_q;
    logic [ROW_W-1:0]  pend_row_q;
    logic [COL_W-1:0]  pend_col_q;

    logic              rd_hit, wr_hit;
    logic              fill_done;
    logic              accept;
    logic [ROWBITS-1:0] arr_row, fill_row;
    logic [DATA_W-1:0]  buf_word, fill_word, hit_word;

    assign rd_ready  = (state_q == RC_IDLE);
    assign accept    = rd_req && rd_ready;
    assign fill_done = (state_q == RC_FILL) && (cnt_q == '0);

    rowcache_array #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_array (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .rd_bank  (pend_bank_q),
        .rd_row   (pend_row_q),
        .row_data (arr_row)
    );

    rowcache_tags #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (fill_done),
        .set_bank (pend_bank_q),
        .set_row  (pend_row_q),
        .rd_bank  (rd_bank),
        .rd_row   (rd_row),
        .rd_hit   (rd_hit),
        .wr_bank  (wr_bank),
        .wr_row   (wr_row),
        .wr_hit   (wr_hit)
    );

    rowcache_rowbuf #(
        .DATA_W (DATA_W),
        .BANK_W (BANK_W),
        .COL_W  (COL_W)
    ) u_rowbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (fill_done),
        .load_bank (pend_bank_q),
        .load_data (fill_row),
        .wr_en     (wr_en),
        .wr_hit    (wr_hit),
        .wr_bank   (wr_bank),
        .wr_col    (wr_col),
        .wr_data   (wr_data),
        .rd_bank   (rd_bank),
        .rd_col    (rd_col),
        .rd_word   (buf_word)
    );

    // Fill row: array contents with a same-cycle write to that row merged in.
    always_comb begin
        fill_row = arr_row;
        if (wr_en && (wr_bank == pend_bank_q) && (wr_row == pend_row_q)) begin
            fill_row[wr_col*DATA_W +: DATA_W] = wr_data;
        end
        fill_word = fill_row[pend_col_q*DATA_W +: DATA_W];
    end

    // Hit data: a write to the same word in this cycle wins.
    always_comb begin
        hit_word = (wr_en && (wr_addr == rd_addr)) ? wr_data : buf_word;
    end

    // Sequencer: take reads, wait out a miss, return data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RC_IDLE;
            cnt_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                RC_IDLE: begin
                    if (accept) begin
                        if (rd_hit) begin
                            rd_valid <= 1'b1;
                            rd_data  <= hit_word;
                        end else begin
                            state_q <= RC_FILL;
                            cnt_q   <= CNT_W'(MISS_LAT - 1);
                        end
                    end
                end
                RC_FILL: begin
                    if (cnt_q == '0) begin
                        state_q  <= RC_IDLE;
                        rd_valid <= 1'b1;
                        rd_data  <= fill_word;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= RC_IDLE;
            endcase
        end
    end

    // Pending miss address: captured when a missing read is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bank_q <= '0;
            pend_row_q  <= '0;
            pend_col_q  <= '0;
        end else if (accept && !rd_hit) begin
            pend_bank_q <= rd_bank;
            pend_row_q  <= rd_row;
            pend_col_q  <= rd_col;
        end
    end

    // Data only ever appears with the controller ready again.
    assert_valid_when_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_ready);

    // A hit answers next cycle without a stall.
    assert_hit_next_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_hit) |=> (rd_valid && rd_ready));

    // A miss drops ready on the following cycle.
    assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !rd_hit) |=> (!rd_ready && !rd_valid));

    // While stalled and not finishing, no data is produced.
    assert_no_valid_in_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RC_FILL) && (cnt_q != '0)) |=> !rd_valid);

endmodule

// File: tb/rowcache_ctrl_test.sv
// Bench: sweeps a small configuration of rowcache_ctrl against an
// arithmetic model of memory contents and per-bank tags.
module rowcache_ctrl_test;
    localparam int DATA_W   = 8;
    localparam int BANK_W   = 2;
    localparam int ROW_W    = 3;
    localparam int COL_W    = 4;
    localparam int MISS_LAT = 4;
    localparam int NBANK    = 1 << BANK_W;
    localparam int ROWS     = 1 << ROW_W;
    localparam int COLS     = 1 << COL_W;
    localparam int AW       = ROW_W + BANK_W + COL_W;
    localparam int DEPTH    = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              rd_ready;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    int model_mem [DEPTH];
    int tag_row   [NBANK];
    bit tag_ok    [NBANK];

    always #10 clk = ~clk;

    rowcache_ctrl #(
        .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .MISS_LAT(MISS_LAT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic int pat(int a, int s);
        return ((a * 29) + (s * 71) + (a >> 4)) & 255;
    endfunction

    function automatic int mk_addr(int r, int b, int c);
        return (r << (BANK_W + COL_W)) | (b << COL_W) | c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Single write cycle; model updated with it.
    task automatic do_write(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DATA_W'(d);
        model_mem[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read with optional colliding write: wmode 1 with the request,
    // 2 in the first stall cycle, 3 in the last stall cycle.
    task automatic do_read(input int a, input int wmode, input int wd, input string req);
        int b, r, lat, lows;
        bit hit;
        b = (a >> COL_W) & (NBANK - 1);
        r = a >> (BANK_W + COL_W);
        hit = tag_ok[b] && (tag_row[b] == r);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a);
        if (wmode == 1) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = DATA_W'(wd); model_mem[a] = wd;
        end
        @(negedge clk);
        rd_req = 1'b0; wr_en = 1'b0;
        lat = 1; lows = 0;
        while (!rd_valid && lat < 50) begin
            if (!rd_ready) begin
                lows++;
                rd_req = 1'b1;                        // R10: ignored while stalled
                rd_addr = AW'(a ^ (1 << COL_W));
                if ((wmode == 2 && lows == 1) || (wmode == 3 && lows == MISS_LAT)) begin
                    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DATA_W'(wd); model_mem[a] = wd;
                end
            end
            @(negedge clk);
            rd_req = 1'b0; wr_en = 1'b0;
            lat++;
        end
        if (hit) begin
            check(lat == 1, {req, " R3 hit latency"}, lat, 1);
        end else begin
            check(lat == MISS_LAT + 1, {req, " R4 miss latency"}, lat, MISS_LAT + 1);
            check(lows == MISS_LAT, {req, " R4 ready low cycles"}, lows, MISS_LAT);
        end
        check(rd_ready == 1'b1, {req, " R4 ready with data"}, int'(rd_ready), 1);
        check(int'(rd_data) == model_mem[a], {req, " R1 data"}, int'(rd_data), model_mem[a]);
        tag_ok[b] = 1'b1; tag_row[b] = r;
        @(negedge clk);
        check(rd_valid == 1'b0, {req, " R10 single pulse"}, int'(rd_valid), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NBANK; b++) begin tag_ok[b] = 1'b0; tag_row[b] = 0; end
        repeat (3) @(negedge clk);
        // R2: reset state
        check(rd_ready == 1'b1, "R2 reset ready", int'(rd_ready), 1);
        check(rd_valid == 1'b0, "R2 reset valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_ready == 1'b1, "R2 ready after reset", int'(rd_ready), 1);

        // R7: back-to-back writes fill the whole array.
        @(negedge clk);
        for (int a = 0; a < DEPTH; a++) begin
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = DATA_W'(pat(a, 0));
            model_mem[a] = pat(a, 0);
            @(negedge clk);
        end
        wr_en = 1'b0;

        // R1 R2 R5: full sweep; first access per bank and each row change miss.
        for (int r = 0; r < ROWS; r++)
            for (int b = 0; b < NBANK; b++)
                for (int c = 0; c < COLS; c++)
                    do_read(mk_addr(r, b, c), 0, 0, "sweep R5");

        // R6: load a different row in each bank, then all columns hit.
        for (int b = 0; b < NBANK; b++) do_read(mk_addr((b + 1) % ROWS, b, 0), 0, 0, "R6 load");
        for (int b = 0; b < NBANK; b++)
            for (int c = 0; c < COLS; c++)
                do_read(mk_addr((b + 1) % ROWS, b, c), 0, 0, "R6 revisit");

        // R8: rewrite cached rows, rows must hit with new data.
        for (int b = 0; b < NBANK; b++)
            for (int c = 0; c < COLS; c++)
                do_write(mk_addr((b + 1) % ROWS, b, c), pat(mk_addr(b, b, c), 1));
        // R7: writes to rows not cached change only the array.
        for (int b = 0; b < NBANK; b++)
            for (int c = 0; c < COLS; c += 3)
                do_write(mk_addr((b + 5) % ROWS, b, c), pat(c, 2));
        for (int b = 0; b < NBANK; b++)
            for (int c = 0; c < COLS; c++)
                do_read(mk_addr((b + 1) % ROWS, b, c), 0, 0, "R8 write-through");
        for (int b = 0; b < NBANK; b++)
            for (int c = 0; c < COLS; c += 3)
                do_read(mk_addr((b + 5) % ROWS, b, c), 0, 0, "R7 array update");

        // R9: read and write to the same word collide.
        for (int b = 0; b < NBANK; b++) begin
            do_read(mk_addr((b + 5) % ROWS, b, 1), 1, 17 + b, "R9 hit collide");
            do_read(mk_addr((b + 2) % ROWS, b, 2), 1, 40 + b, "R9 miss collide");
            do_read(mk_addr((b + 3) % ROWS, b, 5), 2, 90 + b, "R9 first stall write");
            do_read(mk_addr((b + 4) % ROWS, b, 9), 3, 150 + b, "R9 last stall write");
            do_read(mk_addr((b + 4) % ROWS, b, 9), 0, 0, "R9 cached after merge");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule